// File: doc/BRIEF.md
# Sleep State Power Plane Controller

This block holds the current system sleep state (S0 working, or S1, S3, S4, S5) and turns it into three active-low power-plane enables. Each enable covers a nested range of states, so a deeper state always switches off every plane that a lighter state switches off. Software asks for a sleep state by presenting a code with a request strobe. The power button, the ring-indicate input and a long-press override move the system between states without software.

A press of the button while working sends a one-cycle interrupt request to software and does not change the state by itself. A press while asleep wakes the system to S0 and gives a one-cycle wake pulse. Holding the button beyond a parameterised number of seconds forces soft-off (S5) from any state. After a forced soft-off only the button can wake the system, until software next enters a sleep state in the normal way.

The core power-good input is asynchronous and passes through a synchroniser; while it is low the downstream bus is held in reset. The ring-indicate wake enable lives in the always-powered resume domain: it keeps its value when core power is lost and only the resume reset clears it.

Top module: `slp_plane_ctrl`

## Requirements
- R1: While `rsm_rst_n` is low, and after it is released, the state is S5: all three plane outputs low, `bus_rst_n` low until power-good is synchronised, `btn_irq` and `wake_pulse` low, ring wake enable cleared.
- R2: `plane_lite_n` is low in S1, S3, S4 and S5 and high in S0.
- R3: `plane_mid_n` is low in S3, S4 and S5 and high in S0 and S1; it is never low while `plane_lite_n` is high.
- R4: `plane_deep_n` is low only in S4 and S5; it is never low while `plane_mid_n` is high.
- R5: With `slp_req` high in S0, `slp_code` values 1, 3, 4 and 5 move the block to S1, S3, S4 and S5 on that clock edge; codes 0, 2, 6 and 7 are ignored, and any request made while asleep is ignored.
- R6: A press of the button (`pwrbtn_n` going low) in S0 raises `btn_irq` for exactly one cycle and leaves the state at S0.
- R7: A press of the button in any sleep state returns the block to S0 on that edge and raises `wake_pulse` for exactly one cycle.
- R8: Holding `pwrbtn_n` low for HOLD_SEC*CYCLES_PER_SEC+1 consecutive sampled cycles forces S5 from any state; a hold of HOLD_SEC*CYCLES_PER_SEC cycles does not, and releasing the button clears the count.
- R9: With the ring wake enable set and no override lock, `ring_in` high in a sleep state returns the block to S0 with a one-cycle `wake_pulse`; with the enable clear, `ring_in` has no effect.
- R10: After a forced S5 entry, `ring_in` is ignored until the next software sleep entry; the button still wakes the system.
- R11: `bus_rst_n` follows `pwr_ok` through a two-flop synchroniser: it rises on the second clock edge after `pwr_ok` rises, falls on the second edge after it falls, and stays low while `pwr_ok` is low.
- R12: The ring wake enable takes `ri_en_d` when `ri_en_we` is high only while synchronised power-good is high; it keeps its value while power-good is low and is cleared only by `rsm_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-domain clock |
| rsm_rst_n | input | 1 | Resume-domain reset, active low, asynchronous |
| pwr_ok | input | 1 | Core power good, asynchronous |
| pwrbtn_n | input | 1 | Debounced power button, low when pressed |
| ring_in | input | 1 | Ring indicate from the modem, high when ringing |
| ri_en_we | input | 1 | Write strobe for the ring wake enable |
| ri_en_d | input | 1 | Value written to the ring wake enable |
| slp_req | input | 1 | Software sleep request strobe |
| slp_code | input | 3 | Requested state: 1=S1, 3=S3, 4=S4, 5=S5 |
| plane_lite_n | output | 1 | Lightest plane control, low in S1..S5 |
| plane_mid_n | output | 1 | Middle plane control, low in S3..S5 |
| plane_deep_n | output | 1 | Deepest plane control, low in S4, S5 |
| bus_rst_n | output | 1 | Bus reset, low while core power is not good |
| btn_irq | output | 1 | One-cycle request to software on a press in S0 |
| wake_pulse | output | 1 | One-cycle pulse on every wake to S0 |

## Verification
A wrong state register shows on the three plane outputs right after the clock edge that loads it, because they are a pure decode of the state; S4 and S5 look alike there, so the override lock is observed through `ring_in` being ignored or honoured at the next edge. A hold counter that does not clear or that is off by one shows as a soft-off one cycle early, one cycle late, or after an interrupted hold. A lost or overwritten ring enable only shows when a later ring arrives in a sleep state, so the bench writes the enable, cuts core power, tries to overwrite it and then rings from S3.

// File: rtl/slp_pkg.sv
package slp_pkg;

   // State codes double as depth ordering: a larger code is a deeper state.
   typedef enum logic [2:0] {
      ST_S0 = 3'd0,
      ST_S1 = 3'd1,
      ST_S3 = 3'd3,
      ST_S4 = 3'd4,
      ST_S5 = 3'd5
   } slp_state_e;

   localparam int NUM_PLANES = 3;

   // Shallowest state code at which plane i is switched off.
   function automatic logic [2:0] plane_floor(input int idx);
      case (idx)
         0:       plane_floor = 3'd1;
         1:       plane_floor = 3'd3;
         default: plane_floor = 3'd4;
      endcase
   endfunction

   function automatic logic code_valid(input logic [2:0] code);
      code_valid = (code == 3'd1) || (code == 3'd3) ||
                   (code == 3'd4) || (code == 3'd5);
   endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("slp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];

   // R11: output only moves toward a value the input held before
   a_r11_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> (q == $past(sh[STAGES-2])));

endmodule

// File: rtl/slp_hold_timer.sv
module slp_hold_timer #(
   parameter int CYCLES_PER_SEC = 32768,
   parameter int HOLD_SEC       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   output logic fire
);

   if (CYCLES_PER_SEC < 1) begin : g_bad_cps
      $error("slp_hold_timer: CYCLES_PER_SEC must be positive");
   end
   if (HOLD_SEC < 1) begin : g_bad_hold
      $error("slp_hold_timer: HOLD_SEC must be positive");
   end

   localparam int LIMIT = HOLD_SEC * CYCLES_PER_SEC + 1;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!held)       cnt <= '0;
      else if (cnt != LIM_V) cnt <= cnt + 1'b1;
   end

   assign fire = held && (cnt == LIM_M1);

   // R8: count saturates and the override fires once per hold
   always_comb begin
      if (rst_n) a_r8_sat: assert (cnt <= LIM_V);
   end

   a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !held |=> !fire);

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
   import slp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       press,
   input  logic       ovr_fire,
   input  logic       ring_act,
   input  logic       req,
   input  logic [2:0] req_code,
   output slp_state_e st,
   output logic       btn_irq,
   output logic       wake_pulse
);

   slp_state_e st_n;
   logic       lock, lock_n, irq_n, wake_n;

   always_comb begin
      st_n   = st;
      lock_n = lock;
      irq_n  = 1'b0;
      wake_n = 1'b0;
      if (ovr_fire) begin
         st_n   = ST_S5;
         lock_n = 1'b1;
      end else if (st != ST_S0) begin
         if (press || (ring_act && !lock)) begin
            st_n   = ST_S0;
            wake_n = 1'b1;
         end
      end else begin
         irq_n = press;
         if (req && code_valid(req_code)) begin
            st_n   = slp_state_e'(req_code);
            lock_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_S5;
         lock       <= 1'b0;
         btn_irq    <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         st         <= st_n;
         lock       <= lock_n;
         btn_irq    <= irq_n;
         wake_pulse <= wake_n;
      end
   end

   // R5: a sleep state is left only for S0 or a forced S5
   a_r5_sleep_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_S0 && !ovr_fire) |=> (st == $past(st) || st == ST_S0));

   // R10: a locked sleep state ignores the ring input
   a_r10_lock_ignores_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && st != ST_S0 && !press && !ovr_fire) |=> (st == $past(st)));

   // R6: the interrupt request follows a press made while working
   a_r6_irq_from_s0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(btn_irq) |-> ($past(st) == ST_S0));

   // R7: every wake lands in S0 and lasts one cycle
   a_r7_wake_to_s0: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (st == ST_S0));
   a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

endmodule

// File: rtl/slp_plane_dec.sv
module slp_plane_dec
   import slp_pkg::*;
#(
   parameter int PLANES = NUM_PLANES
) (
   input  slp_state_e        st,
   output logic [PLANES-1:0] planes_n
);

   if (PLANES < 1 || PLANES > NUM_PLANES) begin : g_bad_planes
      $error("slp_plane_dec: PLANES out of range");
   end

   for (genvar i = 0; i < PLANES; i++) begin : g_plane
      localparam logic [2:0] FLOOR = plane_floor(i);
      assign planes_n[i] = !(st >= FLOOR);
   end

endmodule

// File: rtl/slp_plane_ctrl.sv
module slp_plane_ctrl
   import slp_pkg::*;
#(
   parameter int CYCLES_PER_SEC = 32768,
   parameter int HOLD_SEC       = 4,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rsm_rst_n,
   input  logic       pwr_ok,
   input  logic       pwrbtn_n,
   input  logic       ring_in,
   input  logic       ri_en_we,
   input  logic       ri_en_d,
   input  logic       slp_req,
   input  logic [2:0] slp_code,
   output logic       plane_lite_n,
   output logic       plane_mid_n,
   output logic       plane_deep_n,
   output logic       bus_rst_n,
   output logic       btn_irq,
   output logic       wake_pulse
);

   logic                  pok_s;
   logic                  held, held_q, press, ovr_fire;
   logic                  ri_en;
   slp_state_e            st;
   logic [NUM_PLANES-1:0] planes_n;

   slp_sync #(.STAGES(SYNC_STAGES)) u_pok_sync (
      .clk  (clk),
      .rst_n(rsm_rst_n),
      .d    (pwr_ok),
      .q    (pok_s)
   );

   assign bus_rst_n = pok_s;

   // Button edge detect: a press is the first sampled low cycle.
   assign held = !pwrbtn_n;

   always_ff @(posedge clk or negedge rsm_rst_n) begin
      if (!rsm_rst_n) held_q <= 1'b0;
      else            held_q <= held;
   end

   assign press = held && !held_q;

   // Ring wake enable: resume-domain sticky bit, writable only with core power.
   always_ff @(posedge clk or negedge rsm_rst_n) begin
      if (!rsm_rst_n)             ri_en <= 1'b0;
      else if (ri_en_we && pok_s) ri_en <= ri_en_d;
   end

   slp_hold_timer #(
      .CYCLES_PER_SEC(CYCLES_PER_SEC),
      .HOLD_SEC      (HOLD_SEC)
   ) u_hold (
      .clk  (clk),
      .rst_n(rsm_rst_n),
      .held (held),
      .fire (ovr_fire)
   );

   slp_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rsm_rst_n),
      .press     (press),
      .ovr_fire  (ovr_fire),
      .ring_act  (ring_in && ri_en),
      .req       (slp_req),
      .req_code  (slp_code),
      .st        (st),
      .btn_irq   (btn_irq),
      .wake_pulse(wake_pulse)
   );

   slp_plane_dec #(.PLANES(NUM_PLANES)) u_dec (
      .st      (st),
      .planes_n(planes_n)
   );

   assign plane_lite_n = planes_n[0];
   assign plane_mid_n  = planes_n[1];
   assign plane_deep_n = planes_n[2];

   // R3, R4: plane ranges are nested
   a_r3_mid_nested: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !plane_mid_n |-> !plane_lite_n);
   a_r4_deep_nested: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !plane_deep_n |-> !plane_mid_n);

   // R12: enable cannot change while core power is not good
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !pok_s |=> $stable(ri_en));

   // R8: a forced soft-off leaves every plane off
   a_r8_override_off: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      ovr_fire |=> (!plane_lite_n && !plane_mid_n && !plane_deep_n));

   // R6: interrupt and wake never coincide
   a_r6_irq_not_wake: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !(btn_irq && wake_pulse));

endmodule

// File: tb/test_slp_plane_ctrl.sv
module test_slp_plane_ctrl;

   localparam int CPS  = 4;
   localparam int HOLD = 4;
   localparam int LIM  = HOLD * CPS;   // longest hold that must not override

   logic       clk = 1'b0;
   logic       rsm_rst_n, pwr_ok, pwrbtn_n, ring_in, ri_en_we, ri_en_d, slp_req;
   logic [2:0] slp_code;
   logic       plane_lite_n, plane_mid_n, plane_deep_n, bus_rst_n, btn_irq, wake_pulse;

   int  total = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   slp_plane_ctrl #(.CYCLES_PER_SEC(CPS), .HOLD_SEC(HOLD)) i_slp_plane_ctrl (
      .clk(clk), .rsm_rst_n(rsm_rst_n), .pwr_ok(pwr_ok), .pwrbtn_n(pwrbtn_n),
      .ring_in(ring_in), .ri_en_we(ri_en_we), .ri_en_d(ri_en_d),
      .slp_req(slp_req), .slp_code(slp_code),
      .plane_lite_n(plane_lite_n), .plane_mid_n(plane_mid_n),
      .plane_deep_n(plane_deep_n), .bus_rst_n(bus_rst_n),
      .btn_irq(btn_irq), .wake_pulse(wake_pulse)
   );

   // Code and expected {lite, mid, deep} after a request from S0 (R5, R2..R4).
   localparam logic [5:0] VEC [8] = '{
      {3'd0, 3'b111}, {3'd1, 3'b011}, {3'd2, 3'b111}, {3'd3, 3'b001},
      {3'd4, 3'b000}, {3'd5, 3'b000}, {3'd6, 3'b111}, {3'd7, 3'b111}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", rq, act, exp);
      end
   endtask

   function automatic logic [2:0] planes();
      return {plane_lite_n, plane_mid_n, plane_deep_n};
   endfunction

   task automatic request(input logic [2:0] code);
      slp_code = code; slp_req = 1'b1;
      tick();
      slp_req = 1'b0;
   endtask

   task automatic tap();
      pwrbtn_n = 1'b0; tick();
      pwrbtn_n = 1'b1; tick();
   endtask

   task automatic hold(input int n);
      pwrbtn_n = 1'b0;
      repeat (n) tick();
      pwrbtn_n = 1'b1; tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      rsm_rst_n = 1'b0; pwr_ok = 1'b0; pwrbtn_n = 1'b1; ring_in = 1'b0;
      ri_en_we = 1'b0; ri_en_d = 1'b0; slp_req = 1'b0; slp_code = 3'd0;
      repeat (3) tick();
      chk("R1 planes in reset", planes(), 3'b000);
      chk("R1 outputs in reset", {bus_rst_n, btn_irq, wake_pulse}, 3'b000);
      rsm_rst_n = 1'b1; tick();
      chk("R1 S5 after reset", planes(), 3'b000);

      // R11 power-good synchroniser latency
      pwr_ok = 1'b1; tick();
      chk("R11 one edge", {2'b00, bus_rst_n}, 3'b000);
      tick();
      chk("R11 two edges", {2'b00, bus_rst_n}, 3'b001);

      // R7 wake from S5 by button
      pwrbtn_n = 1'b0; tick();
      chk("R7 wake pulse", {2'b00, wake_pulse}, 3'b001);
      chk("R7 awake planes", planes(), 3'b111);
      pwrbtn_n = 1'b1; tick();
      chk("R7 wake one cycle", {2'b00, wake_pulse}, 3'b000);

      // R5 table walk with R2, R3, R4 decode
      for (int k = 0; k < 8; k++) begin
         request(VEC[k][5:3]);
         chk($sformatf("R5 R2 R3 R4 code %0d", VEC[k][5:3]), planes(), VEC[k][2:0]);
         if (planes() != 3'b111) begin
            tap();
            chk("R7 back to S0", planes(), 3'b111);
         end
      end

      // R5 request while asleep ignored
      request(3'd3);
      request(3'd1);
      chk("R5 request while asleep", planes(), 3'b001);
      tap();

      // R6 press in S0
      pwrbtn_n = 1'b0; tick();
      chk("R6 irq pulse", {1'b0, btn_irq, wake_pulse}, 3'b010);
      chk("R6 stays S0", planes(), 3'b111);
      pwrbtn_n = 1'b1; tick();
      chk("R6 irq one cycle", {2'b00, btn_irq}, 3'b000);

      // R8 hold boundary and counter clear
      hold(LIM);
      chk("R8 hold at limit no override", planes(), 3'b111);
      hold(10); hold(10);
      chk("R8 interrupted hold cleared", planes(), 3'b111);
      pwrbtn_n = 1'b0;
      repeat (LIM + 1) tick();
      chk("R8 override from S0", planes(), 3'b000);
      pwrbtn_n = 1'b1; tick();

      // R10 ring ignored after override, button still wakes
      ri_en_d = 1'b1; ri_en_we = 1'b1; tick(); ri_en_we = 1'b0;
      ring_in = 1'b1; tick();
      chk("R10 ring ignored planes", planes(), 3'b000);
      chk("R10 ring ignored pulse", {2'b00, wake_pulse}, 3'b000);
      ring_in = 1'b0;
      pwrbtn_n = 1'b0; tick();
      chk("R10 button wakes", {wake_pulse, planes()[2:1]}, 3'b111);
      pwrbtn_n = 1'b1; tick();

      // R9 ring wake after normal entry
      request(3'd3);
      ring_in = 1'b1; tick();
      chk("R9 ring wake pulse", {2'b00, wake_pulse}, 3'b001);
      chk("R9 ring wake planes", planes(), 3'b111);
      ring_in = 1'b0; tick();

      // R9 ring with enable clear
      ri_en_d = 1'b0; ri_en_we = 1'b1; tick(); ri_en_we = 1'b0;
      request(3'd1);
      ring_in = 1'b1; tick();
      chk("R9 disabled ring ignored", planes(), 3'b011);
      ring_in = 1'b0;
      tap();

      // R8 override entered from a sleep state
      request(3'd4);
      pwrbtn_n = 1'b0; tick();
      chk("R8 hold starts with wake", {wake_pulse, planes()[2:1]}, 3'b111);
      repeat (LIM) tick();
      chk("R8 override from sleep", planes(), 3'b000);
      pwrbtn_n = 1'b1; tick();
      tap();

      // R12 enable survives power loss and blocked write
      ri_en_d = 1'b1; ri_en_we = 1'b1; tick(); ri_en_we = 1'b0;
      pwr_ok = 1'b0; tick(); tick();
      chk("R11 bus reset on power loss", {2'b00, bus_rst_n}, 3'b000);
      ri_en_d = 1'b0; ri_en_we = 1'b1; tick(); ri_en_we = 1'b0;
      pwr_ok = 1'b1; tick(); tick();
      request(3'd3);
      ring_in = 1'b1; tick();
      chk("R12 enable retained", {2'b00, wake_pulse}, 3'b001);
      ring_in = 1'b0; tick();

      // R12 resume reset clears the enable
      rsm_rst_n = 1'b0; tick();
      chk("R1 reset forces S5", planes(), 3'b000);
      rsm_rst_n = 1'b1; tick(); tick(); tick();
      tap();
      request(3'd3);
      ring_in = 1'b1; tick();
      chk("R12 enable cleared by reset", {wake_pulse, planes()[2:1]}, 3'b000);
      ring_in = 1'b0; tick();

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule